// File: doc/BRIEF.md
# Parallel Quadrature Tone Generator

This block synthesizes a digital sine and cosine tone whose sample rate is a multiple of the fabric clock. In every clock cycle it computes a group of consecutive output samples, one per lane, so a downstream serializer can play the group out in sequence at the higher rate. A single shared phase accumulator steps by the lane count times the tuning word on each clock. Each lane then adds its own multiple of the tuning word, so the lanes cover successive sample instants of one continuous waveform.

Each lane turns its phase into amplitude with a full-cycle table of 1024 signed 16-bit entries, scaled to ±32767. A plain lookup is only good to about 8 bits, so each lane interpolates linearly between the addressed entry and the next one, using the 8 phase bits below the index as the weight. The cosine comes from the same table with the phase advanced by a quarter cycle. The packed output words carry every lane's sample in time order, and a valid flag marks the words that leave the fixed 3-cycle pipeline.

Top module: `polyphase_nco`

## Requirements
- R1: While `rst` is sampled high, and on the first two clock edges after it falls, `out_valid` is 0. At each reset edge, both sample words are cleared to zero.
- R2: The phase of lane k is `acc + k*ftw` modulo 2^32. `acc` starts at 0 after reset and grows by `LANES*ftw` on each clock.
- R3: A lane's sine output (I is cosine, Q is sine) is within 3 LSB of `32767*sin(2*pi*phase/2^32)`.
- R4: A lane's cosine output is the sine of its phase plus 2^30, to the same 3 LSB accuracy.
- R5: When the low 22 phase bits are zero, the output equals `round(32767*sin(2*pi*idx/1024))` exactly, where idx is phase bits 31..22. For example, phase 0 gives sine 0 and cosine 32767.
- R6: Lane k occupies bits `[16k+15:16k]` of each word, so lane 0 (the earliest sample) is in the least significant position. With a tuning word of 2^30, the sine lanes read 0, 32767, 0, -32767 from lane 0 upward.
- R7: A tuning word presented with `ftw_load` high is used for all lanes from the next edge on. The accumulator step on that same edge still uses the old word, so the phase stays continuous across the word boundary.
- R8: Output data appear 3 clock edges after the accumulator state they come from. `out_valid` rises on the third edge after reset is released and stays high until the next reset.
- R9: Phase wraps modulo 2^32. An index of 1023 interpolates toward entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_load | input | 1 | Load strobe for the tuning word |
| ftw_in | input | 32 | Tuning word (phase step per output sample) |
| out_valid | output | 1 | Words carry pipeline data |
| sin_word | output | LANES*16 | Packed signed sine samples, lane 0 in the LSBs |
| cos_word | output | LANES*16 | Packed signed cosine samples, lane 0 in the LSBs |

## Verification
The bench keeps a reference accumulator and tuning word that it updates at every edge. It also keeps a history of the last four states. A data word sampled after edge t is compared with the state captured after edge t-3, which matches the three registers between the accumulator and the outputs. The valid flag is due on the third non-reset edge, and the bench checks it against a count of edges since reset was released. All outputs are sampled on the falling edge, and inputs change only there.

// File: rtl/pnco_pkg.sv
package pnco_pkg;

    localparam int PHASE_W = 32;
    localparam int IDX_W   = 10;
    localparam int FRAC_W  = 8;
    localparam int AMP_W   = 16;
    localparam int DEPTH   = 1 << IDX_W;
    localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
    localparam int LATENCY = 3;

    typedef logic [PHASE_W-1:0]       phase_t;
    typedef logic [IDX_W-1:0]         idx_t;
    typedef logic [FRAC_W-1:0]        frac_t;
    typedef logic signed [AMP_W-1:0]  amp_t;

    // Two neighbouring table entries plus the interpolation weight
    typedef struct packed {
        amp_t  lo;
        amp_t  hi;
        frac_t frac;
    } span_t;

    localparam phase_t QUARTER = phase_t'(1) << (PHASE_W - 2);

    // Rounded table value at entry i of a full cycle
    function automatic amp_t table_entry(input int i);
        real a;
        a = real'(AMP_MAX) * $sin(2.0 * 3.14159265358979323846 * real'(i) / real'(DEPTH));
        return amp_t'($rtoi($floor(a + 0.5)));
    endfunction

    function automatic idx_t idx_of(input phase_t p);
        return p[PHASE_W-1 -: IDX_W];
    endfunction

    function automatic frac_t frac_of(input phase_t p);
        return p[PHASE_W-IDX_W-1 -: FRAC_W];
    endfunction

    // lo + ((hi - lo) * frac) >>> FRAC_W
    function automatic amp_t lerp(input span_t s);
        logic signed [AMP_W:0]          d;
        logic signed [AMP_W+FRAC_W+1:0] prod;
        d    = $signed({s.hi[AMP_W-1], s.hi}) - $signed({s.lo[AMP_W-1], s.lo});
        prod = d * $signed({1'b0, s.frac});
        return s.lo + amp_t'(prod >>> FRAC_W);
    endfunction

endpackage

// File: rtl/pnco_phase.sv
module pnco_phase
    import pnco_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ftw_load,
    input  phase_t ftw_in,
    output phase_t lane_ph [LANES]
);

    localparam phase_t STRIDE = phase_t'(LANES);

    phase_t acc;
    phase_t ftw_q;
    phase_t ftw_s1;
    phase_t base_ph [LANES];

    // Shared accumulator: one group of LANES samples per clock
    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            ftw_q  <= '0;
            ftw_s1 <= '0;
        end else begin
            acc    <= acc + STRIDE * ftw_q;
            ftw_s1 <= ftw_q;
            if (ftw_load) ftw_q <= ftw_in;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane_ph
        assign base_ph[k] = acc + phase_t'(k) * ftw_q;

        always_ff @(posedge clk) begin
            if (rst) lane_ph[k] <= '0;
            else     lane_ph[k] <= base_ph[k];
        end
    end

    // R2: lane 0 continues one step after the previous group's last lane
    a_r2_lane_continuity: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> lane_ph[0] == $past(lane_ph[LANES-1]) + $past(ftw_s1));

endmodule

// File: rtl/pnco_lane.sv
module pnco_lane
    import pnco_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t lane_ph,
    output idx_t   sin_idx,
    output idx_t   cos_idx,
    input  amp_t   sin_lo,
    input  amp_t   sin_hi,
    input  amp_t   cos_lo,
    input  amp_t   cos_hi,
    output amp_t   sin_o,
    output amp_t   cos_o
);

    phase_t cos_ph;
    span_t  s_sp;
    span_t  c_sp;

    assign cos_ph  = lane_ph + QUARTER;
    assign sin_idx = idx_of(lane_ph);
    assign cos_idx = idx_of(cos_ph);

    // Table read stage
    always_ff @(posedge clk) begin
        if (rst) begin
            s_sp <= '0;
            c_sp <= '0;
        end else begin
            s_sp <= '{lo: sin_lo, hi: sin_hi, frac: frac_of(lane_ph)};
            c_sp <= '{lo: cos_lo, hi: cos_hi, frac: frac_of(cos_ph)};
        end
    end

    // Interpolation stage
    always_ff @(posedge clk) begin
        if (rst) begin
            sin_o <= '0;
            cos_o <= '0;
        end else begin
            sin_o <= lerp(s_sp);
            cos_o <= lerp(c_sp);
        end
    end

    // R3: interpolated sine stays between the two table entries it used
    a_r3_sin_bounded: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
            ((sin_o >= $past(s_sp.lo) && sin_o <= $past(s_sp.hi)) ||
             (sin_o <= $past(s_sp.lo) && sin_o >= $past(s_sp.hi))));

    // R4: same for the quarter-shifted cosine
    a_r4_cos_bounded: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
            ((cos_o >= $past(c_sp.lo) && cos_o <= $past(c_sp.hi)) ||
             (cos_o <= $past(c_sp.lo) && cos_o >= $past(c_sp.hi))));

endmodule

// File: rtl/polyphase_nco.sv
module polyphase_nco
    import pnco_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ftw_load,
    input  logic [PHASE_W-1:0]       ftw_in,
    output logic                     out_valid,
    output logic [LANES*AMP_W-1:0]   sin_word,
    output logic [LANES*AMP_W-1:0]   cos_word
);

    phase_t              lane_ph [LANES];
    logic [LATENCY-1:0]  valid_sr;
    amp_t                wave_rom [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) wave_rom[i] = table_entry(i);
    end

    pnco_phase #(.LANES(LANES)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .ftw_load (ftw_load),
        .ftw_in   (ftw_in),
        .lane_ph  (lane_ph)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        idx_t si;
        idx_t ci;
        amp_t so;
        amp_t co;

        pnco_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .lane_ph (lane_ph[k]),
            .sin_idx (si),
            .cos_idx (ci),
            .sin_lo  (wave_rom[si]),
            .sin_hi  (wave_rom[idx_t'(si + 1'b1)]),
            .cos_lo  (wave_rom[ci]),
            .cos_hi  (wave_rom[idx_t'(ci + 1'b1)]),
            .sin_o   (so),
            .cos_o   (co)
        );

        assign sin_word[k*AMP_W +: AMP_W] = so;
        assign cos_word[k*AMP_W +: AMP_W] = co;
    end

    always_ff @(posedge clk) begin
        if (rst) valid_sr <= '0;
        else     valid_sr <= {valid_sr[LATENCY-2:0], 1'b1};
    end

    assign out_valid = valid_sr[LATENCY-1];

    // R1: a reset edge always leaves the output flagged invalid
    a_r1_reset_drops_valid: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R8: once valid, the flag holds until reset
    a_r8_valid_holds: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid);

endmodule

// File: tb/polyphase_nco_bench.sv
module polyphase_nco_bench;

    localparam int  N      = 4;
    localparam int  AW     = 16;
    localparam real TWO_PI = 6.283185307179586;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ftw_load = 1'b0;
    logic [31:0]     ftw_in = '0;
    logic            out_valid;
    logic [N*AW-1:0] sin_word;
    logic [N*AW-1:0] cos_word;

    always #2 clk = ~clk;

    polyphase_nco #(.LANES(N)) u_polyphase_nco (
        .clk       (clk),
        .rst       (rst),
        .ftw_load  (ftw_load),
        .ftw_in    (ftw_in),
        .out_valid (out_valid),
        .sin_word  (sin_word),
        .cos_word  (cos_word)
    );

    typedef struct {
        logic [31:0] acc;
        logic [31:0] ftw;
    } mstate_t;

    int      checks = 0;
    int      failures = 0;
    bit      done = 1'b0;
    int      cnt = 0;
    string   tag = "R1";
    mstate_t hist [4];

    function automatic real ideal(input logic [31:0] p);
        return 32767.0 * $sin(TWO_PI * real'(p) / 4294967296.0);
    endfunction

    function automatic int rnd(input real x);
        return $rtoi($floor(x + 0.5));
    endfunction

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input string what, input int act, input real exp);
        real d;
        checks++;
        d = real'(act) - exp;
        if (d > 3.0 || d < -3.0) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%f", req, what, act, exp);
        end
    endtask

    // Sampled on the falling edge; hist[3] is the state three edges back
    task automatic check_outputs();
        check_int((cnt < 3) ? "R1" : "R8", "out_valid", int'(out_valid), int'(cnt >= 3));
        if (cnt == 0) begin
            check_int("R1", "sin_word cleared", int'(sin_word != '0), 0);
            check_int("R1", "cos_word cleared", int'(cos_word != '0), 0);
        end
        if (cnt >= 3) begin
            for (int k = 0; k < N; k++) begin
                logic [31:0] p;
                logic [31:0] pc;
                int          a_s;
                int          a_c;
                p   = hist[3].acc + 32'(k) * hist[3].ftw;   // R2 lane phase
                pc  = p + 32'h4000_0000;
                a_s = int'($signed(sin_word[k*AW +: AW]));  // R6 lane slot
                a_c = int'($signed(cos_word[k*AW +: AW]));
                if (p[21:0] == '0) begin
                    // R5 exact at table points
                    check_int(tag, $sformatf("lane%0d sin exact", k), a_s, rnd(ideal(p)));
                    check_int("R4", $sformatf("lane%0d cos exact", k), a_c, rnd(ideal(pc)));
                end else begin
                    check_near(tag, $sformatf("lane%0d sin", k), a_s, ideal(p));
                    check_near("R4", $sformatf("lane%0d cos", k), a_c, ideal(pc));
                end
            end
        end
    endtask

    task automatic step(input bit r, input bit ld, input logic [31:0] f);
        mstate_t nx;
        check_outputs();
        rst      = r;
        ftw_load = ld;
        ftw_in   = f;
        if (r) begin
            nx.acc = '0;
            nx.ftw = '0;
            cnt    = 0;
        end else begin
            // R7: the step on the load edge uses the old word
            nx.acc = hist[0].acc + 32'(N) * hist[0].ftw;
            nx.ftw = ld ? f : hist[0].ftw;
            cnt    = (cnt < 1000) ? cnt + 1 : cnt;
        end
        hist[3] = hist[2];
        hist[2] = hist[1];
        hist[1] = hist[0];
        hist[0] = nx;
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed_init;
        int          since_load;
        seed_init = $urandom(32'd1357);
        for (int i = 0; i < 4; i++) begin
            hist[i].acc = '0;
            hist[i].ftw = '0;
        end
        @(negedge clk);

        tag = "R1";
        repeat (3) step(1'b1, 1'b0, '0);

        tag = "R5";
        repeat (8) step(1'b0, 1'b0, '0);

        tag = "R6";
        step(1'b0, 1'b1, 32'h4000_0000);
        repeat (8) step(1'b0, 1'b0, '0);

        tag = "R9";
        step(1'b0, 1'b1, 32'hFFFF_F800);
        repeat (40) step(1'b0, 1'b0, '0);
        step(1'b0, 1'b1, 32'h7FF0_0000);
        repeat (12) step(1'b0, 1'b0, '0);

        since_load = 0;
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            bit          ld;
            r  = $urandom;
            ld = (r % 6) == 0;
            since_load = ld ? 0 : since_load + 1;
            tag = (since_load < 4) ? "R7" : "R2";
            step(1'b0, ld, $urandom);
        end

        tag = "R1";
        repeat (2) step(1'b1, 1'b0, '0);

        tag = "R3";
        step(1'b0, 1'b1, $urandom);
        repeat (24) step(1'b0, 1'b0, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule